// File: doc/BRIEF.md
# Read Sampling Delay Calibration Sequencer

This block searches for a read sampling delay that works at a chosen serial flash clock divider. When started, it has the flash read engine fetch a calibration region of `AREA_WORDS` 32-bit words at a slow, safe speed. It folds that region into a CRC-32 reference signature, using the reflected polynomial 0xEDB88320 with all-ones initial value, one 32-bit word per step. The same pass also counts how many words carry real content. If the region is usable, the block walks through twelve delay settings. It writes each setting into the selected divider's 4-bit field of a timing register. For each setting it reads the region again at target speed, up to ten times, and compares each signature with the reference.

A setting passes only if every one of its reads matches. The search ends at the first run of three consecutive passing settings. The block then keeps the setting just before the last one of that run, so one passing neighbour remains on each side. If no run is found, or the reference is too uniform, the block reports failure and the timing register keeps the value it had before the start. The flash engine is outside this block. It reads word by word on request, uses the slow clock while `rd_slow` is high, and otherwise samples with the delay held in `timing_reg`.

Top module: `rd_delay_cal`

## Requirements
- R1: After reset `timing_reg` is all zeros and `done`, `fail`, `rd_req` and `rd_slow` are low.
- R2: Each pass over the region requests word addresses 0 to AREA_WORDS-1 in ascending order. `rd_req` is a one-cycle pulse and the next request waits for `rd_valid`. The reference pass runs with `rd_slow` high and all later passes with it low.
- R3: Trial settings are tried in index order 0 to 11. Index i is written as the 4-bit code {i is even, i/2}: bit 3 is the input-delay enable, set for even i, and bits 2:0 hold i/2. The code goes into `timing_reg` bits (d-1)*4+3 down to (d-1)*4, where d is the divider.
- R4: No bit of `timing_reg` outside the selected 4-bit field ever changes during a calibration.
- R5: A setting passes only if all ten reads of it match the reference signature. A mismatch on any read fails the setting at once, including a mismatch on the tenth read. The next setting then starts.
- R6: When three consecutive settings pass, ending at index k, the field is loaded with the code of index k-1. `done` then pulses with `fail` low.
- R7: A failing setting resets the count of consecutive passes, so two passes, a failure and one more pass do not complete a run.
- R8: If fewer than MIN_VARIED (64 by default) reference words differ from both 0x00000000 and 0xFFFFFFFF, the block pulses `done` with `fail` high. No trial read is made and `timing_reg` is unchanged. Exactly MIN_VARIED such words is enough to continue.
- R9: If all twelve settings are tried without a run of three, `done` pulses with `fail` high and the field gets back the value it held at start.
- R10: A divider of 0 or above TREG_W/4 makes no read. `done` pulses with `fail` high on the cycle after `start`.
- R11: `done` is high for exactly one cycle per calibration. `fail` keeps its value until the next accepted start, which clears it. A `start` during a calibration is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a calibration (accepted only when idle) |
| div_sel | input | DIV_W | Clock divider d whose timing field is calibrated |
| rd_req | output | 1 | One-cycle request for one word from the flash engine |
| rd_addr | output | $clog2(AREA_WORDS) | Word index within the calibration region |
| rd_slow | output | 1 | High while the reference pass is read at safe speed |
| rd_valid | input | 1 | Read data valid, one cycle |
| rd_data | input | 32 | Read data word |
| timing_reg | output | TREG_W | Timing register, one 4-bit field per divider |
| done | output | 1 | One-cycle end-of-calibration pulse |
| fail | output | 1 | Calibration failed, held until next start |

## Verification
The bench goes after mismatches that fall on the last of the ten reads of a setting. A design that stops early, after fewer reads, would accept that setting and pick a different field code. It also tries runs broken just before completion and a run that ends on the final setting. Off-by-one run counting or a wrong choice of the kept neighbour shows up there as a wrong code. Further cases are the validity threshold at exactly MIN_VARIED words and one word short of it, and a failed search after an earlier success on the same divider. A design that forgot the prior field would leave the code of setting 11 in place. Invalid dividers, the top field of the register and a restart pulse during a run are also covered. These expose a miscomputed field position, which corrupts neighbouring fields, or a restarted sequence, which changes the number of words read.

// File: rtl/rd_delay_cal.sv
module rd_delay_cal #(
  parameter int AREA_WORDS = 4096,
  parameter int READS      = 10,
  parameter int NUM_SET    = 12,
  parameter int RUN_LEN    = 3,
  parameter int MIN_VARIED = 64,
  parameter int TREG_W     = 32,
  parameter int DIV_W      = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [DIV_W-1:0]              div_sel,
  output logic                          rd_req,
  output logic [$clog2(AREA_WORDS)-1:0] rd_addr,
  output logic                          rd_slow,
  input  logic                          rd_valid,
  input  logic [31:0]                   rd_data,
  output logic [TREG_W-1:0]             timing_reg,
  output logic                          done,
  output logic                          fail
);
  localparam int AW   = $clog2(AREA_WORDS);
  localparam int NF   = TREG_W / 4;
  localparam int RW   = $clog2(READS + 1);
  localparam int RUNW = $clog2(RUN_LEN + 1);
  localparam int VW   = $clog2(AREA_WORDS + 1);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_END} st_t;

  st_t             st;
  logic [DIV_W-1:0] fidx;
  logic [3:0]      old_f;
  logic            ref_phase;
  logic [AW-1:0]   addr;
  logic [31:0]     crc, ref_crc;
  logic [VW-1:0]   varied;
  logic [3:0]      set_idx;
  logic [RW-1:0]   reads;
  logic [RUNW-1:0] run;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [31:0] d);
    logic [31:0] r;
    r = c ^ d;
    for (int k = 0; k < 32; k++)
      r = r[0] ? ((r >> 1) ^ 32'hEDB8_8320) : (r >> 1);
    return r;
  endfunction

  function automatic logic [3:0] enc(input logic [3:0] i);
    return {~i[0], i[3:1]};
  endfunction

  wire [DIV_W-1:0] new_idx = div_sel - DIV_W'(1);
  wire div_ok = (div_sel != '0) && (div_sel <= DIV_W'(NF));
  wire match  = (crc == ref_crc);
  wire word_varied = (rd_data != 32'h0) && (rd_data != 32'hFFFF_FFFF);

  assign rd_req  = (st == S_REQ);
  assign rd_addr = addr;
  assign rd_slow = ref_phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; fidx <= '0; old_f <= '0; ref_phase <= 1'b0;
      addr <= '0; crc <= '1; ref_crc <= '0; varied <= '0;
      set_idx <= '0; reads <= '0; run <= '0;
      timing_reg <= '0; done <= 1'b0; fail <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          fail <= 1'b0;
          fidx <= new_idx;
          if (!div_ok) begin
            done <= 1'b1;
            fail <= 1'b1;
          end else begin
            old_f     <= timing_reg[{new_idx, 2'b00} +: 4];
            ref_phase <= 1'b1;
            addr      <= '0;
            crc       <= '1;
            varied    <= '0;
            st        <= S_REQ;
          end
        end
        S_REQ: st <= S_WAIT;
        S_WAIT: if (rd_valid) begin
          crc <= crc_step(crc, rd_data);
          if (ref_phase && word_varied) varied <= varied + VW'(1);
          if (addr == AW'(AREA_WORDS - 1)) begin
            addr <= '0;
            st   <= S_END;
          end else begin
            addr <= addr + AW'(1);
            st   <= S_REQ;
          end
        end
        S_END: begin
          crc <= '1;
          if (ref_phase) begin
            ref_crc   <= crc;
            ref_phase <= 1'b0;
            if (varied < VW'(MIN_VARIED)) begin
              done <= 1'b1;
              fail <= 1'b1;
              st   <= S_IDLE;
            end else begin
              set_idx <= '0;
              run     <= '0;
              reads   <= '0;
              timing_reg[{fidx, 2'b00} +: 4] <= enc(4'd0);
              st      <= S_REQ;
            end
          end else if (match && reads != RW'(READS - 1)) begin
            reads <= reads + RW'(1);
            st    <= S_REQ;
          end else if (match && run == RUNW'(RUN_LEN - 1)) begin
            timing_reg[{fidx, 2'b00} +: 4] <= enc(set_idx - 4'd1);
            done <= 1'b1;
            st   <= S_IDLE;
          end else begin
            run <= match ? run + RUNW'(1) : '0;
            if (set_idx == 4'(NUM_SET - 1)) begin
              timing_reg[{fidx, 2'b00} +: 4] <= old_f;
              done <= 1'b1;
              fail <= 1'b1;
              st   <= S_IDLE;
            end else begin
              set_idx <= set_idx + 4'd1;
              reads   <= '0;
              timing_reg[{fidx, 2'b00} +: 4] <= enc(set_idx + 4'd1);
              st      <= S_REQ;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rd_delay_cal_chk.sv
module rd_delay_cal_chk #(
  parameter int TREG_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              rd_req,
  input logic              rd_slow,
  input logic [TREG_W-1:0] timing_reg,
  input logic              done,
  input logic              fail
);
  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_FAIL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(fail) || done)); // R11
  AST_REF_NO_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    rd_slow |-> $stable(timing_reg)); // R8
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!rd_req && !rd_slow)); // R11
endmodule

bind rd_delay_cal rd_delay_cal_chk #(.TREG_W(TREG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .rd_req(rd_req), .rd_slow(rd_slow),
  .timing_reg(timing_reg), .done(done), .fail(fail)
);

// File: tb/rd_delay_cal_bench.sv
module rd_delay_cal_bench;
  localparam int AREA  = 16;
  localparam int READS = 10;
  localparam int MINV  = 4;
  localparam int NEVER = 99;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  div_sel = 4'd1;
  logic        rd_req, rd_slow, rd_valid = 1'b0, done, fail;
  logic [3:0]  rd_addr;
  logic [31:0] rd_data = '0, timing_reg;

  int tests = 0, failed = 0;
  int fa[12];
  logic [31:0] mem[AREA];
  int cur_div = 1;
  int exp_addr = 0, words = 0, served = 0, last_s = -1;
  int addr_err = 0, ord_err = 0, oth_err = 0, done_cnt = 0;
  int pend = 0, cnt = 0, reqn = 0, cur_a = 0;
  logic running = 1'b0;
  logic [31:0] t0;

  always #2 clk = ~clk;

  rd_delay_cal #(.AREA_WORDS(AREA), .READS(READS), .MIN_VARIED(MINV)) u_rd_delay_cal (
    .clk(clk), .rst_n(rst_n), .start(start), .div_sel(div_sel),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_slow(rd_slow),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .timing_reg(timing_reg), .done(done), .fail(fail));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int dec(input logic [3:0] f);
    return int'(f[2:0]) * 2 + (f[3] ? 0 : 1);
  endfunction

  function automatic logic [3:0] enc(input int i);
    return {i % 2 == 0, 3'(i / 2)};
  endfunction

  // flash engine model and per-clock monitors
  always @(negedge clk) begin
    logic [31:0] d;
    logic [31:0] msk;
    rd_valid = 1'b0;
    if (done) done_cnt++;
    if (running && cur_div >= 1 && cur_div <= 8) begin
      msk = 32'hF << ((cur_div - 1) * 4);
      if ((timing_reg & ~msk) != (t0 & ~msk)) oth_err++;
    end
    if (pend != 0) begin
      cnt--;
      if (cnt == 0) begin
        pend = 0;
        d = mem[cur_a];
        if (!rd_slow) begin
          int s;
          s = dec(timing_reg[(cur_div - 1) * 4 +: 4]);
          if (s != last_s) begin
            if (s != last_s + 1) ord_err++;
            last_s = s;
            served = 0;
          end
          if (cur_a == 3 && fa[s] == served / AREA) d = d ^ 32'h1;
          served++;
        end else begin
          last_s = -1;
          served = 0;
        end
        rd_valid = 1'b1;
        rd_data = d;
      end
    end
    if (rd_req) begin
      if (int'(rd_addr) != exp_addr) addr_err++;
      exp_addr = (exp_addr + 1) % AREA;
      cur_a = int'(rd_addr);
      words++;
      pend = 1;
      cnt = 1 + (reqn % 3);
      reqn++;
    end
  end

  task automatic fill(input int mode);
    for (int a = 0; a < AREA; a++) begin
      case (mode)
        0: mem[a] = (32'h1234_5679 * (a + 1)) ^ a;
        1: mem[a] = (a < MINV - 1) ? a + 5 : ((a == 8) ? 32'hFFFF_FFFF : 32'h0);
        default: mem[a] = (a < MINV) ? 32'hA5A5_0000 + a : 32'hFFFF_FFFF;
      endcase
    end
  endtask

  task automatic run_case(input string req, input int div, input int mode,
                          input logic [47:0] pat, input logic restart);
    int res, run, ew, nv, cyc;
    logic ef;
    logic [31:0] et;
    @(negedge clk);
    for (int s = 0; s < 12; s++) fa[s] = (pat[s*4 +: 4] == 4'hF) ? NEVER : int'(pat[s*4 +: 4]);
    fill(mode);
    t0 = timing_reg;
    cur_div = div; exp_addr = 0; words = 0; addr_err = 0; ord_err = 0;
    oth_err = 0; done_cnt = 0; last_s = -1; served = 0;
    // reference model of the outcome
    nv = 0;
    for (int a = 0; a < AREA; a++) if (mem[a] != 0 && mem[a] != 32'hFFFF_FFFF) nv++;
    res = -1; ew = 0; run = 0; et = t0; ef = 1'b1;
    if (div >= 1 && div <= 8) begin
      ew = AREA;
      if (nv >= MINV) begin
        for (int s = 0; s < 12; s++) begin
          if (fa[s] >= READS) begin
            ew += READS * AREA; run++;
            if (run == 3) begin res = s - 1; break; end
          end else begin
            ew += (fa[s] + 1) * AREA; run = 0;
          end
        end
        if (res >= 0) begin
          et[(div - 1) * 4 +: 4] = enc(res);
          ef = 1'b0;
        end
      end
    end
    running = 1'b1;
    start = 1'b1; div_sel = 4'(div);
    @(negedge clk);
    start = 1'b0;
    if (div < 1 || div > 8) chk({req, " done next cycle"}, {31'h0, done}, 32'h1);
    cyc = 0;
    while (done_cnt == 0 && cyc < 30000) begin
      if (restart && cyc == 200) begin start = 1'b1; div_sel = 4'd6; end
      else start = 1'b0;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk({req, " finished"}, {31'h0, done_cnt != 0}, 32'h1);
    chk({req, " fail"}, {31'h0, fail}, {31'h0, ef});
    chk({req, " timing_reg"}, timing_reg, et);
    chk({req, " R5 R7 words read"}, words, ew);
    chk({req, " R2 address order"}, addr_err, 0);
    chk({req, " R3 setting order"}, ord_err, 0);
    chk({req, " R4 other fields"}, oth_err, 0);
    running = 1'b0;
    repeat (6) @(negedge clk);
    chk({req, " R11 done pulse count"}, done_cnt, 1);
    chk({req, " R11 fail held"}, {31'h0, fail}, {31'h0, ef});
  endtask

  initial begin
    #800000;
    failed++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 timing_reg", timing_reg, 32'h0);
    chk("R1 done/fail", {30'h0, done, fail}, 32'h0);
    chk("R1 rd_req/rd_slow", {30'h0, rd_req, rd_slow}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    // R6 all pass on divider 1
    run_case("R6 all pass", 1, 0, 48'hFFFF_FFFF_FFFF, 1'b0);
    // R5 mismatch on tenth read of setting 2, R3 field at bits 11:8
    run_case("R5 last read", 3, 0, 48'hFFF_FFF_F9F_0 & 48'hFFFF_FFFF_F9F0, 1'b0);
    // R7 broken runs, run finishes at setting 10, top field
    run_case("R7 broken runs", 8, 0, 48'hFFFF_0FF2_FF5F, 1'b0);
    // R9 no run of three on divider 3, field restored
    run_case("R9 no run", 3, 0, 48'h0F0F_0F0F_0F0F, 1'b0);
    // R8 one word short of threshold
    run_case("R8 too uniform", 5, 1, 48'hFFFF_FFFF_FFFF, 1'b0);
    // R8 exactly at threshold
    run_case("R8 threshold", 5, 2, 48'hFFFF_FFFF_FFF0, 1'b0);
    // R6 run ends on the final setting
    run_case("R6 last setting", 7, 0, 48'hFFF0_0000_0000, 1'b0);
    // R11 start pulse during a run is ignored
    run_case("R11 restart ignored", 4, 0, 48'hFFFF_FFFF_FFF0, 1'b1);
    // R10 invalid dividers
    run_case("R10 div 0", 0, 0, 48'hFFFF_FFFF_FFFF, 1'b0);
    run_case("R10 div 9", 9, 0, 48'hFFFF_FFFF_FFFF, 1'b0);
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule